// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block is a 32-bit register slave that holds a colour lookup table. The table has 256 pixel entries, followed by 4 overlay entries that are used for the cursor. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads an entry number into an index register. It then streams the components through a data offset. A small phase counter selects red, green or blue in turn, and the index steps forward on its own once blue has been handled.

The overlay entries are reached through their own data offset. That offset uses only the two low bits of the index. Reads walk the same phase and index sequence as writes, so software can dump the whole table by issuing back-to-back reads. A separate combinational lookup port gives display logic the packed colour of any entry, at any time.

Top module: `pal_dac_port`

## Requirements
- R1: A full-word write to offset 0 loads the entry index from write data bits 31:24 and sets the component phase back to red (phase 0), even when the write arrives in the middle of a triple.
- R2: Full-word writes to offset 4 store write data bits 31:24 into the red, green and blue component of pixel entry `index`, in that order, as the phase goes 0, 1, 2. Bits 23:0 of the write data are not used.
- R3: After the blue step, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: Full-word writes to offset 12 follow the same phase sequence and index increment, but they store into overlay entry 256 + index[1:0].
- R5: A full-word read with the write enable low returns the current component of pixel entry `index` in bits 31:24, with bits 23:0 zero, and advances phase and index exactly as a write does.
- R6: A full-word write to any offset other than 0, 4 or 12 changes neither the table, nor the index, nor the phase.
- R7: After reset, entries 255, 256 and 258 are white (every component 0xFF), all other components are zero, the index is 0 and the phase is red.
- R8: An access with any byte enable low is ignored entirely: the table, the index and the phase are unchanged.
- R9: The lookup port takes a 9-bit entry number and returns red in bits 23:16, green in 15:8 and blue in 7:0, in the same cycle. Entry numbers above 259 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write access this cycle |
| busRdEn | input | 1 | Read access this cycle; a read is served only when busWrEn is low |
| busAddr | input | 4 | Byte offset of the access |
| busBe | input | 4 | Byte enables; all four must be high for an access to take effect |
| busWrData | input | 32 | Write data; the component or index is in bits 31:24 |
| busRdData | output | 32 | Component at the current phase of entry `index`, in bits 31:24 |
| lkIdx | input | 9 | Entry number for the display lookup |
| lkRgb | output | 24 | Packed red, green and blue of entry lkIdx |

## Verification
A phase counter that has drifted shows up at the next read. That read returns the wrong component in bits 31:24, and a following lookup shows the colour landing in the wrong slot of the triple. An index that went wrong, or that wrapped wrongly, is exposed by the first store after it: the lookup port then shows the change in a neighbouring entry, or in a pixel entry instead of an overlay entry. Both are visible within one access. Ignored accesses are proven harmless by following them with a store or a read whose result would differ if the index or phase had moved.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int PIX_ENTRIES = 256;
  localparam int OVL_ENTRIES = 4;
  localparam int TOTAL_ENTRIES = PIX_ENTRIES + OVL_ENTRIES;
  localparam int COMP_W = 8;
  localparam int RGB_W = 3 * COMP_W;
  localparam int IDX_W = $clog2(PIX_ENTRIES);
  localparam int OVL_W = $clog2(OVL_ENTRIES);
  localparam int ENTRY_W = $clog2(TOTAL_ENTRIES);

  // byte offsets decoded by the control side
  localparam int OFS_INDEX = 0;
  localparam int OFS_PIXEL = 4;
  localparam int OFS_OVERLAY = 12;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2,
    PH_SPARE = 2'd3
  } palPhase_t;

  // strobe bundle from control to table
  typedef struct packed {
    logic               wrEn;
    logic [ENTRY_W-1:0] entry;
    palPhase_t          comp;
  } palStrobe_t;
endpackage

// File: rtl/pal_dac_ctrl.sv
module pal_dac_ctrl
  import pal_dac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W/8-1:0]  busBe,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output palStrobe_t           strobe,
  output logic [ENTRY_W-1:0]   rdEntry,
  output palPhase_t            rdComp,
  input  logic [COMP_W-1:0]    rdByte
);
  localparam int TOP_BIT = DATA_W - 1;
  localparam int LOW_W = DATA_W - COMP_W;

  logic [IDX_W-1:0] idxQ;
  palPhase_t        phaseQ;

  logic fullWord, ldIdx, wrPix, wrOvl, rdGo, stepEn;
  logic [COMP_W-1:0] dataByte;

  assign fullWord = &busBe;
  assign ldIdx    = busWrEn && fullWord && (busAddr == ADDR_W'(OFS_INDEX));
  assign wrPix    = busWrEn && fullWord && (busAddr == ADDR_W'(OFS_PIXEL));
  assign wrOvl    = busWrEn && fullWord && (busAddr == ADDR_W'(OFS_OVERLAY));
  assign rdGo     = busRdEn && !busWrEn && fullWord;
  assign stepEn   = wrPix || wrOvl || rdGo;
  assign dataByte = busWrData[TOP_BIT -: COMP_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      phaseQ <= PH_RED;
    end else if (ldIdx) begin
      idxQ   <= dataByte[IDX_W-1:0];
      phaseQ <= PH_RED;
    end else if (stepEn) begin
      case (phaseQ)
        PH_RED:   phaseQ <= PH_GREEN;
        PH_GREEN: phaseQ <= PH_BLUE;
        PH_BLUE: begin
          phaseQ <= PH_RED;
          idxQ   <= idxQ + 1'b1;
        end
        default:  phaseQ <= PH_RED;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn  = (wrPix || wrOvl) && (phaseQ != PH_SPARE);
    strobe.comp  = phaseQ;
    strobe.entry = wrOvl ? ENTRY_W'(PIX_ENTRIES) + ENTRY_W'(idxQ[OVL_W-1:0])
                         : ENTRY_W'(idxQ);
  end

  assign rdEntry   = ENTRY_W'(idxQ);
  assign rdComp    = phaseQ;
  assign busRdData = {rdByte, {LOW_W{1'b0}}};

  // R1: index load takes the top byte and restarts the triple
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    ldIdx |=> (idxQ == $past(dataByte[IDX_W-1:0])) && (phaseQ == PH_RED));

  // R3: blue step wraps phase and bumps the index
  p_blue_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !ldIdx && phaseQ == PH_BLUE) |=>
      (phaseQ == PH_RED) && (idxQ == $past(idxQ) + 1'b1));

  // R3: the spare phase code is never held
  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ != PH_SPARE);

  // R4: overlay stores never reach the pixel half
  p_overlay_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && busAddr == ADDR_W'(OFS_OVERLAY)) |->
      (strobe.entry >= ENTRY_W'(PIX_ENTRIES)));

  // R6: unknown offsets leave the sequencer alone
  p_unknown_ofs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && fullWord && busAddr != ADDR_W'(OFS_INDEX) &&
     busAddr != ADDR_W'(OFS_PIXEL) && busAddr != ADDR_W'(OFS_OVERLAY)) |=>
      $stable(idxQ) && $stable(phaseQ));

  // R8: partial-width accesses leave the sequencer alone
  p_partial_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((busWrEn || busRdEn) && !fullWord) |=> $stable(idxQ) && $stable(phaseQ));
endmodule

// File: rtl/pal_dac_table.sv
module pal_dac_table
  import pal_dac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strobe,
  input  logic [COMP_W-1:0]  wrByte,
  input  logic [ENTRY_W-1:0] rdEntry,
  input  palPhase_t          rdComp,
  output logic [COMP_W-1:0]  rdByte,
  input  logic [ENTRY_W-1:0] lkIdx,
  output logic [RGB_W-1:0]   lkRgb
);
  logic [COMP_W-1:0] redT [TOTAL_ENTRIES];
  logic [COMP_W-1:0] grnT [TOTAL_ENTRIES];
  logic [COMP_W-1:0] bluT [TOTAL_ENTRIES];

  function automatic logic whiteAt(input int e);
    return (e == PIX_ENTRIES - 1) || (e == PIX_ENTRIES) || (e == PIX_ENTRIES + 2);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < TOTAL_ENTRIES; e++) begin
        redT[e] <= whiteAt(e) ? '1 : '0;
        grnT[e] <= whiteAt(e) ? '1 : '0;
        bluT[e] <= whiteAt(e) ? '1 : '0;
      end
    end else if (strobe.wrEn) begin
      case (strobe.comp)
        PH_RED:   redT[strobe.entry] <= wrByte;
        PH_GREEN: grnT[strobe.entry] <= wrByte;
        PH_BLUE:  bluT[strobe.entry] <= wrByte;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rdComp)
      PH_RED:   rdByte = redT[rdEntry];
      PH_GREEN: rdByte = grnT[rdEntry];
      PH_BLUE:  rdByte = bluT[rdEntry];
      default:  rdByte = '0;
    endcase
  end

  always_comb begin
    if (lkIdx < ENTRY_W'(TOTAL_ENTRIES))
      lkRgb = {redT[lkIdx], grnT[lkIdx], bluT[lkIdx]};
    else
      lkRgb = '0;
  end

  // R9: without a store the looked-up colour of a held entry cannot move
  p_lookup_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($stable(lkIdx) -> $stable(lkRgb)));

  // R9: entries past the table read as black
  p_lookup_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lkIdx >= ENTRY_W'(TOTAL_ENTRIES)) |-> (lkRgb == '0));
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] busBe,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [ENTRY_W-1:0]  lkIdx,
  output logic [RGB_W-1:0]    lkRgb
);
  palStrobe_t         strobe;
  logic [ENTRY_W-1:0] rdEntry;
  palPhase_t          rdComp;
  logic [COMP_W-1:0]  rdByte;

  pal_dac_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busBe(busBe), .busWrData(busWrData), .busRdData(busRdData),
    .strobe(strobe), .rdEntry(rdEntry), .rdComp(rdComp), .rdByte(rdByte)
  );

  pal_dac_table u_table (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrByte(busWrData[DATA_W-1 -: COMP_W]),
    .rdEntry(rdEntry), .rdComp(rdComp), .rdByte(rdByte),
    .lkIdx(lkIdx), .lkRgb(lkRgb)
  );
endmodule

// File: tb/pal_dac_port_bench.sv
`timescale 1ns/1ps
module pal_dac_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [3:0]  busBe = 4'hF;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [8:0]  lkIdx = '0;
  logic [23:0] lkRgb;

  always #2.5 clk = ~clk;

  pal_dac_port u_pal_dac_port (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busBe(busBe), .busWrData(busWrData),
    .busRdData(busRdData), .lkIdx(lkIdx), .lkRgb(lkRgb)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  // reference model built from the requirements
  logic [7:0] mR[260], mG[260], mB[260];
  int mIdx, mPh;

  task automatic modelReset();
    for (int e = 0; e < 260; e++) begin
      logic [7:0] v;
      v = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      mR[e] = v; mG[e] = v; mB[e] = v;
    end
    mIdx = 0; mPh = 0;
  endtask

  function automatic logic [7:0] modelComp();
    case (mPh)
      0: return mR[mIdx];
      1: return mG[mIdx];
      2: return mB[mIdx];
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelStep(input bit ovl, input bit wr, input logic [7:0] b);
    int e;
    e = ovl ? 256 + (mIdx % 4) : mIdx;
    if (wr) begin
      case (mPh)
        0: mR[e] = b;
        1: mG[e] = b;
        2: mB[e] = b;
        default: ;
      endcase
    end
    if (mPh == 2) begin mPh = 0; mIdx = (mIdx + 1) % 256; end
    else mPh = mPh + 1;
  endtask

  task automatic busWrite(input logic [3:0] addr, input logic [31:0] data,
                          input logic [3:0] be = 4'hF);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data; busBe = be;
    if (be == 4'hF) begin
      if (addr == 4'd0) begin mIdx = int'(data[31:24]); mPh = 0; end
      else if (addr == 4'd4) modelStep(1'b0, 1'b1, data[31:24]);
      else if (addr == 4'd12) modelStep(1'b1, 1'b1, data[31:24]);
    end
    @(posedge clk); #1;
    busWrEn = 1'b0; busBe = 4'hF;
  endtask

  task automatic busRead(input string tag);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = 4'd4; busBe = 4'hF;
    expQ.push_back({modelComp(), 24'h0});
    tagQ.push_back(tag);
    modelStep(1'b0, 1'b0, 8'h00);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  // monitor: compares served reads against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (busRdEn && !busWrEn && busBe == 4'hF) begin
      logic [31:0] e;
      string t;
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected read: actual=%h expected=none", busRdData);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          bad++;
          $display("FAIL %s read: actual=%h expected=%h", t, busRdData, e);
        end
      end
    end
  end

  task automatic checkLut(input int idx, input logic [23:0] exp, input string tag);
    @(negedge clk);
    lkIdx = 9'(idx);
    #1;
    total++;
    if (lkRgb !== exp) begin
      bad++;
      $display("FAIL %s lookup %0d: actual=%h expected=%h", tag, idx, lkRgb, exp);
    end
  endtask

  function automatic logic [23:0] mRgb(input int e);
    return {mR[e], mG[e], mB[e]};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R7: reset contents
    checkLut(0,   24'h000000, "R7");
    checkLut(255, 24'hFFFFFF, "R7");
    checkLut(256, 24'hFFFFFF, "R7");
    checkLut(257, 24'h000000, "R7");
    checkLut(258, 24'hFFFFFF, "R7");
    checkLut(259, 24'h000000, "R7");
    busRead("R7"); // index 0 red, phase 0

    // R1: index load restarts the triple (read above left phase at green)
    busWrite(4'd0, 32'h0500_0000);
    // R2: red, green, blue stores with noise in low bits
    busWrite(4'd4, 32'h12AB_CDEF);
    busWrite(4'd4, 32'h3400_0001);
    busWrite(4'd4, 32'h56FF_FFFF);
    checkLut(5, 24'h123456, "R2");
    // R3: next store lands in entry 6 red
    busWrite(4'd4, 32'hAA00_0000);
    checkLut(6, 24'hAA0000, "R3");

    // R1: load mid-triple restarts at red
    busWrite(4'd0, 32'h0900_0000);
    busWrite(4'd4, 32'h1100_0000);
    busWrite(4'd0, 32'h0900_0000);
    busWrite(4'd4, 32'h2200_0000);
    checkLut(9, 24'h220000, "R1");

    // R3: wrap from 255 to 0
    busWrite(4'd0, 32'hFF00_0000);
    busWrite(4'd4, 32'h0100_0000);
    busWrite(4'd4, 32'h0200_0000);
    busWrite(4'd4, 32'h0300_0000);
    checkLut(255, 24'h010203, "R3");
    busWrite(4'd4, 32'h7700_0000);
    checkLut(0, 24'h770000, "R3");

    // R4: overlay through offset 12, index 7 -> entry 259
    busWrite(4'd0, 32'h0700_0000);
    busWrite(4'd12, 32'hC100_0000);
    busWrite(4'd12, 32'hC200_0000);
    busWrite(4'd12, 32'hC300_0000);
    checkLut(259, 24'hC1C2C3, "R4");
    checkLut(7, mRgb(7), "R4");
    busRead("R4"); // index advanced to 8

    // R5: read back entry 5 and step into entry 6
    busWrite(4'd0, 32'h0500_0000);
    busRead("R5");
    busRead("R5");
    busRead("R5");
    busRead("R5");

    // R6: offset 8 store ignored
    busWrite(4'd0, 32'h2000_0000);
    busWrite(4'd8, 32'h5500_0000);
    busWrite(4'd4, 32'h6600_0000);
    checkLut(32, 24'h660000, "R6");
    checkLut(257, mRgb(257), "R6");

    // R8: partial byte enables ignored
    busWrite(4'd0, 32'h3000_0000, 4'h8);
    busWrite(4'd4, 32'h9900_0000, 4'h7);
    busWrite(4'd4, 32'h4400_0000);
    checkLut(32, 24'h664400, "R8");
    checkLut(48, 24'h000000, "R8");

    // R9: out of range lookup
    checkLut(300, 24'h000000, "R9");
    checkLut(511, 24'h000000, "R9");

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R5 reads missing: actual=%0d expected=0", expQ.size());
    end
    finish();
  end
endmodule